// File: doc/BRIEF.md
# Instruction Cycle and Flush Sequencer

This block sets the instruction timing of a small core with 16-bit program words. It splits the oscillator clock into instruction cycles of four phases. At the end of each cycle it latches the word returned by a synchronous program memory into an instruction register, and it pulses a program-counter advance or load strobe. For every cycle it decides whether the datapath executes the word held in the instruction register or treats the cycle as a no-op bubble.

An outside decoder looks at the instruction register. It reports an operation class for it, and the datapath reports whether a condition holds. From these two inputs the sequencer does three things:
- It lets a two-word instruction run for two cycles.
- It flushes the already-fetched word after a taken skip or a redirect.
- It reloads the program counter after a taken branch.

A word whose upper four bits are all ones is the second word of a two-word instruction. It executes only as that continuation. Reached any other way, it becomes a bubble. A skip that lands on a two-word instruction therefore needs no extra state.

Top module: `instr_cycle_seq`

## Requirements
- R1: While reset is held, and through the whole first instruction cycle after the internal reset releases (two clocks after `rst_n` rises), `bubble` is 1, `exec_en` is 0 and `pc_load` is 0. During reset `phase` is 0 and `pc_inc` is 0. In phase 3 of that first cycle `pc_inc` is 1, so the fetch of address zero completes.
- R2: `phase` steps 0, 1, 2, 3 and wraps back to 0, one step per clock.
- R3: `fetch_word` is sampled on the clock edge that ends phase 3. It is shown on `ir_word` for the whole next instruction cycle.
- R4: `exec_en` and `bubble` are complements of each other. Both hold constant across all four phases of a cycle.
- R5: `pc_inc` and `pc_load` are high only in phase 3. In every phase 3, exactly one of them is high.
- R6: `op_class` and `cond_true` are sampled only in a cycle that executes the first word of an instruction. In a bubble cycle or a continuation cycle they have no effect. The class encoding is: 0 single, 1 two-word, 2 skip, 3 branch, 4 two-word branch.
- R7: After a class-1 word executes, the next cycle executes as its continuation, whatever the prefix of the next word.
- R8: A class-2 word with `cond_true`=1 makes the next cycle a bubble. With `cond_true`=0 it has no effect.
- R9: A class-3 word with `cond_true`=1 gives `pc_load`=1 (and `pc_inc`=0) in phase 3, and the next cycle is a bubble. With `cond_true`=0, `pc_inc`=1 and the next cycle executes.
- R10: A class-4 word always takes three cycles, and `cond_true` is ignored. The first cycle executes. The second executes as a continuation and gives `pc_load`=1 in its phase 3. The third is a bubble.
- R11: A word whose bits 15:12 are 4'b1111 and that is not a continuation runs as a bubble. This includes the second word of a two-word instruction reached by a taken skip.
- R12: Class codes 5 to 7 behave as class 0: no flush, no continuation, no load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_word | input | 16 | Word returned by program memory for the current fetch |
| op_class | input | 3 | Class of the word in `ir_word`, from the decoder |
| cond_true | input | 1 | Condition for a skip or branch holds |
| phase | output | 2 | Phase index within the instruction cycle |
| exec_en | output | 1 | Datapath executes `ir_word` in this cycle |
| bubble | output | 1 | This cycle is a no-op |
| pc_inc | output | 1 | Advance program counter by one word |
| pc_load | output | 1 | Load program counter with branch target |
| ir_word | output | 16 | Instruction register contents |

## Verification
The hardest case to produce from the ports is a taken skip whose target is a two-word instruction. It needs a skip word with its condition, then a first word, then a 1111-prefixed second word, all lined up on cycle boundaries. The outcome is two bubbles in a row that come from different causes.

A directed run builds this sequence, as well as a two-word branch and classes offered during bubble and continuation cycles. A long seeded random run then feeds random words (a quarter of them with the 1111 prefix), classes and conditions on every clock. The random classes include the unused codes 5 to 7. A cycle-level model in the bench checks every output against this stream.

// File: rtl/isq_pkg.sv
package isq_pkg;
  typedef enum logic [2:0] {
    CLS_SINGLE  = 3'd0,
    CLS_DOUBLE  = 3'd1,
    CLS_SKIP    = 3'd2,
    CLS_BRANCH  = 3'd3,
    CLS_DBRANCH = 3'd4
  } op_class_e;
endpackage

// File: rtl/isq_rst_sync.sv
module isq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_int_n = sync_q[STAGES-1];
endmodule

// File: rtl/isq_phase_gen.sv
module isq_phase_gen #(
  parameter int PHASES = 4,
  localparam int PH_W = $clog2(PHASES)
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [PH_W-1:0] phase,
  output logic            last_phase
);
  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] phase_d;

  assign last_phase = (phase_q == PH_W'(PHASES - 1));

  always_comb begin
    if (last_phase) phase_d = '0;
    else            phase_d = phase_q + PH_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign phase = phase_q;

  // R2
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !last_phase |=> (phase_q == $past(phase_q) + PH_W'(1)));
endmodule

// File: rtl/isq_word_reg.sv
module isq_word_reg #(
  parameter int WORD_W   = 16,
  parameter int PREFIX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [WORD_W-1:0] word_in,
  output logic [WORD_W-1:0] word_out,
  output logic              prefix_ones
);
  logic [WORD_W-1:0] ir_q;
  logic [WORD_W-1:0] ir_d;

  always_comb begin
    ir_d = ir_q;
    if (load_en) ir_d = word_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ir_q <= '0;
    else        ir_q <= ir_d;
  end

  assign word_out    = ir_q;
  assign prefix_ones = &ir_q[WORD_W-1 -: PREFIX_W];

  // R3
  ir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(ir_q));
endmodule

// File: rtl/isq_flow_ctrl.sv
module isq_flow_ctrl
  import isq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       last_phase,
  input  logic       prefix_ones,
  input  logic [2:0] op_class,
  input  logic       cond_true,
  output logic       exec_en,
  output logic       bubble,
  output logic       pc_inc,
  output logic       pc_load
);
  logic flush_q, flush_d;
  logic cont_q,  cont_d;
  logic dbr_q,   dbr_d;
  logic first_word;
  logic taken;
  logic skip_taken;
  logic is_double;

  assign exec_en    = !flush_q && (cont_q || !prefix_ones);
  assign bubble     = !exec_en;
  assign first_word = exec_en && !cont_q;
  assign is_double  = (op_class == CLS_DOUBLE) || (op_class == CLS_DBRANCH);
  assign skip_taken = first_word && (op_class == CLS_SKIP) && cond_true;
  assign taken      = (first_word && (op_class == CLS_BRANCH) && cond_true)
                    || (cont_q && dbr_q);

  assign pc_load = last_phase && taken;
  assign pc_inc  = last_phase && !taken;

  always_comb begin
    flush_d = flush_q;
    cont_d  = cont_q;
    dbr_d   = dbr_q;
    if (last_phase) begin
      flush_d = taken || skip_taken;
      cont_d  = first_word && is_double;
      dbr_d   = first_word && (op_class == CLS_DBRANCH);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_q <= 1'b1;
      cont_q  <= 1'b0;
      dbr_q   <= 1'b0;
    end else begin
      flush_q <= flush_d;
      cont_q  <= cont_d;
      dbr_q   <= dbr_d;
    end
  end

  // R5
  pc_quiet_after_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_phase |=> !(pc_inc || pc_load));

  // R9
  flush_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> bubble);

  // R4
  slot_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !last_phase |=> $stable(exec_en));

  // R8
  skip_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_phase && skip_taken) |=> bubble);

  // R10
  dbranch_cont_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_phase && first_word && op_class == CLS_DBRANCH) |=> exec_en);
endmodule

// File: rtl/instr_cycle_seq.sv
module instr_cycle_seq #(
  parameter int WORD_W   = 16,
  parameter int PREFIX_W = 4,
  parameter int PHASES   = 4,
  parameter int CLS_W    = 3,
  localparam int PH_W    = $clog2(PHASES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] fetch_word,
  input  logic [CLS_W-1:0]  op_class,
  input  logic              cond_true,
  output logic [PH_W-1:0]   phase,
  output logic              exec_en,
  output logic              bubble,
  output logic              pc_inc,
  output logic              pc_load,
  output logic [WORD_W-1:0] ir_word
);
  logic rst_int_n;
  logic last_phase;
  logic prefix_ones;

  isq_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  isq_phase_gen #(.PHASES(PHASES)) phase_gen_i (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .phase      (phase),
    .last_phase (last_phase)
  );

  isq_word_reg #(.WORD_W(WORD_W), .PREFIX_W(PREFIX_W)) word_reg_i (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .load_en     (last_phase),
    .word_in     (fetch_word),
    .word_out    (ir_word),
    .prefix_ones (prefix_ones)
  );

  isq_flow_ctrl flow_ctrl_i (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .last_phase  (last_phase),
    .prefix_ones (prefix_ones),
    .op_class    (op_class),
    .cond_true   (cond_true),
    .exec_en     (exec_en),
    .bubble      (bubble),
    .pc_inc      (pc_inc),
    .pc_load     (pc_load)
  );
endmodule

// File: tb/instr_cycle_seq_tb_top.sv
`timescale 1ns/1ps
module instr_cycle_seq_tb_top;
  logic        clk;
  logic        rst_n;
  logic [15:0] fetch_word;
  logic [2:0]  op_class;
  logic        cond_true;
  logic [1:0]  phase;
  logic        exec_en, bubble, pc_inc, pc_load;
  logic [15:0] ir_word;

  int total_checks = 0;
  int fail_checks  = 0;
  bit done = 0;

  instr_cycle_seq dut_i (
    .clk(clk), .rst_n(rst_n), .fetch_word(fetch_word), .op_class(op_class),
    .cond_true(cond_true), .phase(phase), .exec_en(exec_en), .bubble(bubble),
    .pc_inc(pc_inc), .pc_load(pc_load), .ir_word(ir_word)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  // cycle-level reference model
  logic [1:0]  m_sync;
  logic [1:0]  m_phase;
  logic        m_flush, m_cont, m_dbr;
  logic [15:0] m_ir;

  function automatic bit f_exec(bit fl, bit ct, logic [15:0] ir);
    return !fl && (ct || ir[15:12] != 4'hF);
  endfunction

  function automatic bit f_taken(bit ex, bit ct, bit db, logic [2:0] cls, bit cd);
    return (ex && !ct && cls == 3'd3 && cd) || (ct && db);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync <= 2'b00; m_phase <= 0; m_flush <= 1; m_cont <= 0; m_dbr <= 0; m_ir <= 0;
    end else begin
      m_sync <= {m_sync[0], 1'b1};
      if (m_sync[1]) begin
        m_phase <= m_phase + 2'd1;
        if (m_phase == 2'd3) begin
          bit ex, tk, fw;
          ex = f_exec(m_flush, m_cont, m_ir);
          fw = ex && !m_cont;
          tk = f_taken(ex, m_cont, m_dbr, op_class, cond_true);
          m_flush <= tk || (fw && op_class == 3'd2 && cond_true);
          m_cont  <= fw && (op_class == 3'd1 || op_class == 3'd4);
          m_dbr   <= fw && op_class == 3'd4;
          m_ir    <= fetch_word;
        end
      end
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    total_checks++;
    if (act !== exp) begin
      fail_checks++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // continuous model comparison away from the clock edge
  always @(negedge clk) begin
    if (!done) begin
      bit ex, tk, lst;
      ex  = f_exec(m_flush, m_cont, m_ir);
      lst = (m_phase == 2'd3);
      tk  = f_taken(ex, m_cont, m_dbr, op_class, cond_true);
      chk("R2", "phase", 32'(phase), 32'(m_phase));
      chk("R3", "ir_word", 32'(ir_word), 32'(m_ir));
      chk("R4", "exec_en", 32'(exec_en), 32'(ex));
      chk("R4", "bubble", 32'(bubble), 32'(!ex));
      chk("R5", "pc_inc", 32'(pc_inc), 32'(lst && !tk));
      chk("R5", "pc_load", 32'(pc_load), 32'(lst && tk));
    end
  end

  bit          cyc_exec;
  bit          cyc_inc, cyc_load;
  logic [15:0] cyc_ir;

  task automatic drive_cycle(input logic [15:0] w, input logic [2:0] c, input bit k);
    fetch_word = w; op_class = c; cond_true = k;
    cyc_exec = exec_en; cyc_ir = ir_word;
    repeat (3) begin @(posedge clk); #1; end
    cyc_inc = pc_inc; cyc_load = pc_load;
    @(posedge clk); #1;
  endtask

  initial begin : watchdog
    #(5ns * 150000);
    if (!done) begin
      done = 1;
      total_checks++; fail_checks++;
      $display("FAIL watchdog: actual expired expected finish");
      $display("%0d/%0d checks passed", total_checks - fail_checks, total_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 0; fetch_word = 16'h0000; op_class = 3'd0; cond_true = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "reset bubble", 32'(bubble), 32'd1);
    chk("R1", "reset exec_en", 32'(exec_en), 32'd0);
    chk("R1", "reset phase", 32'(phase), 32'd0);
    chk("R1", "reset pc_inc", 32'(pc_inc), 32'd0);
    rst_n = 1;
    do begin @(posedge clk); #1; end while (!m_sync[1]);

    drive_cycle(16'h1234, 3'd3, 1);     // first cycle: class offered but bubble
    chk("R1", "first cycle bubble", 32'(cyc_exec), 32'd0);
    chk("R1", "first cycle pc_inc", 32'(cyc_inc), 32'd1);
    chk("R1", "first cycle pc_load", 32'(cyc_load), 32'd0);
    drive_cycle(16'h2000, 3'd0, 0);     // IR=1234
    chk("R3", "ir after first fetch", 32'(cyc_ir), 32'h1234);
    chk("R1", "second cycle executes", 32'(cyc_exec), 32'd1);
    drive_cycle(16'h3AAA, 3'd2, 1);     // IR=2000 skip taken
    chk("R8", "skip word executes", 32'(cyc_exec), 32'd1);
    drive_cycle(16'hF055, 3'd1, 0);     // IR=3AAA flushed, class ignored
    chk("R8", "skipped word bubble", 32'(cyc_exec), 32'd0);
    drive_cycle(16'h4000, 3'd0, 0);     // IR=F055 reached alone
    chk("R11", "orphan second word bubble", 32'(cyc_exec), 32'd0);
    chk("R6", "class ignored in bubble", 32'(cyc_ir), 32'hF055);
    drive_cycle(16'hF0AA, 3'd1, 0);     // IR=4000 two-word
    chk("R7", "first of two-word executes", 32'(cyc_exec), 32'd1);
    drive_cycle(16'h5000, 3'd2, 1);     // IR=F0AA continuation, skip ignored
    chk("R7", "continuation executes", 32'(cyc_exec), 32'd1);
    drive_cycle(16'h5100, 3'd3, 0);     // IR=5000 branch not taken
    chk("R6", "skip ignored in continuation", 32'(cyc_exec), 32'd1);
    chk("R9", "untaken branch pc_inc", 32'(cyc_inc), 32'd1);
    chk("R9", "untaken branch pc_load", 32'(cyc_load), 32'd0);
    drive_cycle(16'h6000, 3'd3, 1);     // IR=5100 branch taken
    chk("R9", "untaken branch next executes", 32'(cyc_exec), 32'd1);
    chk("R9", "taken branch pc_load", 32'(cyc_load), 32'd1);
    chk("R9", "taken branch pc_inc", 32'(cyc_inc), 32'd0);
    drive_cycle(16'h7000, 3'd3, 1);     // IR=6000 flushed
    chk("R9", "after branch bubble", 32'(cyc_exec), 32'd0);
    chk("R6", "branch in bubble no load", 32'(cyc_load), 32'd0);
    drive_cycle(16'hF123, 3'd4, 0);     // IR=7000 two-word branch
    chk("R10", "dbranch first executes", 32'(cyc_exec), 32'd1);
    chk("R10", "dbranch first pc_inc", 32'(cyc_inc), 32'd1);
    drive_cycle(16'h8000, 3'd0, 0);     // IR=F123 continuation
    chk("R10", "dbranch continuation executes", 32'(cyc_exec), 32'd1);
    chk("R10", "dbranch continuation pc_load", 32'(cyc_load), 32'd1);
    drive_cycle(16'h9000, 3'd0, 0);     // IR=8000 flushed
    chk("R10", "dbranch third cycle bubble", 32'(cyc_exec), 32'd0);
    drive_cycle(16'hA000, 3'd6, 1);     // IR=9000 unused class
    chk("R12", "unused class pc_inc", 32'(cyc_inc), 32'd1);
    chk("R12", "unused class pc_load", 32'(cyc_load), 32'd0);
    drive_cycle(16'hB000, 3'd2, 0);     // IR=A000 skip not taken
    chk("R12", "unused class no flush", 32'(cyc_exec), 32'd1);
    drive_cycle(16'hF777, 3'd0, 0);     // IR=B000
    chk("R8", "untaken skip next executes", 32'(cyc_exec), 32'd1);
    drive_cycle(16'hC000, 3'd0, 0);     // IR=F777 stray
    chk("R11", "stray prefix bubble", 32'(cyc_exec), 32'd0);
    chk("R3", "stray word in ir", 32'(cyc_ir), 32'hF777);

    for (int i = 0; i < 12000; i++) begin
      logic [15:0] w;
      w = 16'($urandom);
      if (($urandom % 4) == 0) w[15:12] = 4'hF;
      fetch_word = w;
      op_class   = 3'($urandom % 8);
      cond_true  = 1'($urandom % 2);
      @(posedge clk); #1;
    end

    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", total_checks - fail_checks, total_checks);
    $finish;
  end
endmodule